// File: doc/BRIEF.md
# Serial-Bus Audio Equalizer Control Receiver

This block is a write-only I2C slave that sits behind a chip's bus pins and turns bus writes into the control settings of an audio path: one attenuation index for the volume stage and one boost/cut setting for each of five equalizer bands. It samples SCL and SDA on the system clock, finds START and STOP, and matches a 7-bit address whose lowest bit comes from a strap input. When the address matches, it acknowledges the write.

After the address, the host may send any number of data bytes before STOP. Bit 7 of each byte selects what the byte controls, so volume and band settings can be mixed in any order in one transfer. Each byte is decoded and applied on its own as soon as its eighth bit is sampled. The outputs are plain registers that take fixed defaults at reset. The SDA output is an open-drain enable: when `sda_oe` is high, the pad pulls the line low.

Top module: `audio_ctl_slave`

## Requirements
- R1: A write addressed to 7-bit address {6'b100001, addr_sel} with R/W = 0 (byte 0x84 when addr_sel = 0, 0x86 when addr_sel = 1) is acknowledged by holding sda_oe high through the ninth SCL pulse.
- R2: After an address byte that does not match, or that carries R/W = 1, the block gives no acknowledge. It also acknowledges and applies nothing until the next START.
- R3: Every data byte of a matching write is acknowledged, up to the STOP. Each byte is decoded on its own, and outputs change only when a data byte completes.
- R4: A data byte with bit 7 = 0 sets vol_atten (units of 0.375 dB) to bits[5:3]*8 + bits[2:0]. Bit 6 is ignored.
- R5: In a volume byte whose bits[5:3] are 6 or 7, vol_atten saturates at 47, whatever bits[2:0] hold.
- R6: A data byte with bit 7 = 1 writes band (bits[6:4] + 1) for band codes 0 to 4. That band's 4-bit field in eq_bands (bits [4k+3:4k] for code k) becomes {bit 3, bits[2:0]}, where bit 3 = 1 means boost and bits[2:0] is the magnitude in 2 dB steps.
- R7: An equalizer byte with band code 5, 6 or 7 is still acknowledged but changes no output.
- R8: Reset sets vol_atten to 46 (17.25 dB) and every band field to 4'b0110 (cut, 12 dB).
- R9: A START in the middle of a byte discards the partial byte, and the next eight bits are taken as an address.
- R10: After a STOP, SCL pulses are ignored (no acknowledge, no change) until a START.
- R11: sda_oe changes only while the synchronized SCL is low, and it is released after the falling edge that ends the ninth pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap giving the lowest address bit |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| vol_atten | output | 6 | Volume attenuation index, 0.375 dB per unit |
| eq_bands | output | 20 | Five 4-bit band fields {boost, magnitude} |

## Verification
Two things can land in the same cycle. One is the completion of a byte, when the bit counter wraps and the byte is committed. The other is the bus-condition detector seeing a START or a STOP. The bench drives them close together in two ways. It sends a STOP a quarter period after the acknowledge of a final data byte. It also breaks off a byte after four bits with a repeated START. The outcome is judged at the ports. The last byte before a STOP must still be applied. A byte that is cut short must change nothing, and the address that follows must be acknowledged.

// File: rtl/aeq_pkg.sv
package aeq_pkg;

    localparam int BYTE_W   = 8;
    localparam int VOL_W    = 6;
    localparam int MAG_W    = 3;
    localparam int BAND_W   = MAG_W + 1;
    localparam int VOL_MAX  = 47;
    localparam int VOL_RST  = 46;
    localparam int COARSE_LIMIT = 5;
    localparam logic [5:0] ADDR_HI = 6'b100001;

    typedef struct packed {
        logic             boost;
        logic [MAG_W-1:0] mag;
    } eq_set_t;

    localparam eq_set_t EQ_RST = '{boost: 1'b0, mag: 3'd6};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_DATA,
        ST_IGNORE
    } rx_state_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic sel);
        return (b[7:1] == {ADDR_HI, sel}) && (b[0] == 1'b0);
    endfunction

    function automatic logic [VOL_W-1:0] vol_index(input logic [BYTE_W-1:0] b);
        logic [VOL_W-1:0] idx;
        if (b[5:3] > 3'(COARSE_LIMIT))
            idx = VOL_W'(VOL_MAX);
        else
            idx = {b[5:3], b[2:0]};
        return idx;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic sync_o,
    output logic prev_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-1:0], din};
    end

    assign sync_o = chain[STAGES-1];
    assign prev_o = chain[STAGES];
endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
    import aeq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_byte,
    output rx_state_t         state
);
    logic                scl_rise, scl_fall, bus_start, bus_stop;
    logic [2:0]          bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   next_byte;

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
    assign next_byte = {shreg[BYTE_W-2:0], sda_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            wr_valid <= 1'b0;
            wr_byte  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (bus_start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (bus_stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise) begin
                            shreg   <= next_byte;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                if (state == ST_ADDR) begin
                                    state <= addr_hit(next_byte, addr_sel) ? ST_ACK_WAIT : ST_IGNORE;
                                end else begin
                                    wr_valid <= 1'b1;
                                    wr_byte  <= next_byte;
                                    state    <= ST_ACK_WAIT;
                                end
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_DRV;
                        end
                    end
                    ST_ACK_DRV: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eq_cmd_decode.sv
module eq_cmd_decode
    import aeq_pkg::*;
#(
    parameter int NBANDS = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic [BYTE_W-1:0]        wr_byte,
    output logic [VOL_W-1:0]         vol_atten,
    output logic [NBANDS*BAND_W-1:0] eq_bands,
    output logic [NBANDS-1:0]        band_we
);
    logic is_eq;
    assign is_eq = wr_byte[7];

    always_ff @(posedge clk) begin
        if (rst)
            vol_atten <= VOL_W'(VOL_RST);
        else if (wr_valid && !is_eq)
            vol_atten <= vol_index(wr_byte);
    end

    for (genvar k = 0; k < NBANDS; k++) begin : g_band
        eq_set_t cur;
        assign band_we[k] = wr_valid && is_eq && (wr_byte[6:4] == 3'(k));

        always_ff @(posedge clk) begin
            if (rst)
                cur <= EQ_RST;
            else if (band_we[k])
                cur <= '{boost: wr_byte[3], mag: wr_byte[2:0]};
        end

        assign eq_bands[k*BAND_W +: BAND_W] = cur;
    end
endmodule

// File: rtl/audio_ctl_slave.sv
module audio_ctl_slave
    import aeq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NBANDS      = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic                     addr_sel,
    output logic                     sda_oe,
    output logic [VOL_W-1:0]         vol_atten,
    output logic [NBANDS*BAND_W-1:0] eq_bands
);
    logic              scl_s, scl_p, sda_s, sda_p;
    logic              wr_valid;
    logic [BYTE_W-1:0] wr_byte;
    logic [NBANDS-1:0] band_we;
    rx_state_t         rx_state;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst(rst), .din(scl_i), .sync_o(scl_s), .prev_o(scl_p)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst(rst), .din(sda_i), .sync_o(sda_s), .prev_o(sda_p)
    );

    i2c_wr_rx u_rx (
        .clk(clk), .rst(rst),
        .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
        .addr_sel(addr_sel),
        .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .state(rx_state)
    );

    eq_cmd_decode #(.NBANDS(NBANDS)) u_dec (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_byte(wr_byte),
        .vol_atten(vol_atten), .eq_bands(eq_bands), .band_we(band_we)
    );
endmodule

// File: rtl/aeq_checker.sv
module aeq_checker
    import aeq_pkg::*;
#(
    parameter int NBANDS = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     scl_s,
    input logic                     sda_oe,
    input logic                     wr_valid,
    input rx_state_t                rx_state,
    input logic [NBANDS-1:0]        band_we,
    input logic [VOL_W-1:0]         vol_atten,
    input logic [NBANDS*BAND_W-1:0] eq_bands
);
    // R5
    vol_max_chk: assert property (@(posedge clk) disable iff (rst)
        vol_atten <= VOL_W'(VOL_MAX));

    // R11
    ack_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_s));

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_state == ST_IGNORE) |-> !sda_oe);

    // R7
    band_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(band_we));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_valid) |-> ($stable(vol_atten) && $stable(eq_bands)));
endmodule

bind audio_ctl_slave aeq_checker #(.NBANDS(NBANDS)) u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .rx_state(rx_state), .band_we(band_we),
    .vol_atten(vol_atten), .eq_bands(eq_bands)
);

// File: tb/sim_audio_ctl_slave.sv
module sim_audio_ctl_slave;
    localparam int TQ = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic [5:0]  vol_atten;
    logic [19:0] eq_bands;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    audio_ctl_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel(addr_sel), .sda_oe(sda_oe),
        .vol_atten(vol_atten), .eq_bands(eq_bands)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * TQ) @(negedge clk);
    endtask

    function automatic int band(input int k);
        return int'(eq_bands[k*4 +: 4]);
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = (sda_bus == 1'b0);
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(a, ack);
        send_byte(d, ack);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R8 reset volume", vol_atten, 46);
        for (int k = 0; k < 5; k++) check("R8 reset band", band(k), 6);
        check("R11 idle sda_oe", sda_oe, 0);
    endtask

    task automatic t_addr();
        logic ack;
        addr_sel = 1'b0;
        bus_start(); send_byte(8'h84, ack); bus_stop();
        check("R1 ack 0x84 sel0", ack, 1);
        bus_start(); send_byte(8'h86, ack); bus_stop();
        check("R2 nack 0x86 sel0", ack, 0);
        addr_sel = 1'b1;
        bus_start(); send_byte(8'h86, ack);
        check("R1 ack 0x86 sel1", ack, 1);
        check("R11 released after ack", sda_oe, 0);
        send_byte(8'h05, ack);
        check("R3 data ack", ack, 1);
        bus_stop();
        check("R4 vol fine only", vol_atten, 5);
        addr_sel = 1'b0;
    endtask

    task automatic t_volume();
        write_one(8'h84, 8'h13);
        check("R4 vol coarse2 fine3", vol_atten, 19);
        write_one(8'h84, 8'h00);
        check("R4 vol zero", vol_atten, 0);
        write_one(8'h84, 8'h53);
        check("R4 bit6 ignored", vol_atten, 19);
        write_one(8'h84, 8'h2F);
        check("R4 vol coarse5 fine7", vol_atten, 47);
        write_one(8'h84, 8'h01);
        write_one(8'h84, 8'h38);
        check("R5 coarse7 saturates", vol_atten, 47);
        write_one(8'h84, 8'h01);
        write_one(8'h84, 8'h32);
        check("R5 coarse6 saturates", vol_atten, 47);
    endtask

    task automatic t_eq();
        write_one(8'h84, 8'hAD);
        check("R6 band3 boost 10dB", band(2), 13);
        check("R6 band1 untouched", band(0), 6);
        write_one(8'h84, 8'hC3);
        check("R6 band5 cut 6dB", band(4), 3);
        write_one(8'h84, 8'h8F);
        check("R6 band1 boost 14dB", band(0), 15);
        write_one(8'h84, 8'hEF);
        check("R7 code6 no change vol", vol_atten, 47);
        check("R7 code6 band5", band(4), 3);
        check("R7 code6 band1", band(0), 15);
    endtask

    task automatic t_multi();
        logic ack;
        logic [7:0] seq [4] = '{8'h0A, 8'h99, 8'hB4, 8'hF1};
        int acks = 0;
        bus_start();
        send_byte(8'h84, ack);
        foreach (seq[i]) begin
            send_byte(seq[i], ack);
            acks += int'(ack);
        end
        bus_stop();
        check("R3 all bytes acked", acks, 4);
        check("R3 multi vol", vol_atten, 10);
        check("R3 multi band2", band(1), 9);
        check("R3 multi band4", band(3), 4);
        check("R7 multi code7 band5", band(4), 3);
    endtask

    task automatic t_read_and_mismatch();
        logic ack;
        bus_start(); send_byte(8'h85, ack);
        check("R2 read nack", ack, 0);
        send_byte(8'h17, ack);
        check("R2 after read nack", ack, 0);
        bus_stop();
        check("R2 after read vol", vol_atten, 10);
        bus_start(); send_byte(8'h90, ack);
        send_byte(8'h81, ack);
        check("R2 mismatch data nack", ack, 0);
        bus_stop();
        check("R2 mismatch band1", band(0), 15);
    endtask

    task automatic t_restart();
        logic ack;
        bus_start(); send_byte(8'h84, ack);
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(8'h84, ack);
        check("R9 restart addr ack", ack, 1);
        send_byte(8'h21, ack);
        bus_stop();
        check("R9 restart vol", vol_atten, 33);
    endtask

    task automatic t_after_stop();
        logic ack;
        send_byte(8'h84, ack);
        check("R10 no start nack", ack, 0);
        send_byte(8'h02, ack);
        check("R10 no start vol", vol_atten, 33);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_addr();
        t_volume();
        t_eq();
        t_multi();
        t_read_and_mismatch();
        t_restart();
        t_after_stop();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule